// File: doc/BRIEF.md
# Byte-Register Bridge to a 16-bit Asynchronous Memory

This block gives a host, which only has an 8-bit register port, access to a 16-bit asynchronous external memory (a flash part and a pseudo-static RAM that share address and data lines). The host sets a 24-bit byte address through three address bytes. It selects the target chip and its side-band lines through a control byte. It then moves 16-bit words through a pair of data bytes. Touching the low data byte starts the actual memory cycle. The high byte is either staged ahead of a write or holds the upper half of the word fetched by a read.

Each memory cycle holds the word address and chip selects for a fixed, parameterised number of clocks. It asserts output-enable for a read or pulses write-enable for a write, and samples the read data on the last clock. The register-port acknowledge for the triggering access is held back until the memory cycle ends, so the byte returned is fresh. An optional auto-increment moves the address to the next word after every triggered cycle. A single ownership input decides whether the memory pins follow this bridge or pass straight through from a device-side port.

Top module: `xmem_bridge`

## Requirements
- R1: After reset the control byte reads 0xC4 (bit 7 = 1, bit 6 = 1, bit 2 = 1, others 0), the address bytes and the high data byte read 0, both chip selects, output-enable and write-enable are high (inactive), the data bus is not driven, and the flash reset line is high.
- R2: Register offsets on the 4-bit port: 8 control, 9/10/11 address bits 7:0, 15:8 and 23:16, 12 data low, 13 data high. Offsets 8 to 11 and 13 read back what was written. Any other offset reads 0, and writes to it change nothing.
- R3: The control byte drives the memory side-band lines: bit 7 drives the flash reset line (active low) and bit 1 drives the RAM configuration-enable line (active high). During a memory cycle bit 6 = 0 selects the flash and bit 2 = 0 selects the RAM. If both are 0, both selects are asserted.
- R4: The memory word address equals address bits 23:1, and address bit 0 has no effect on which word is accessed.
- R5: A write to offset 13 only stores the byte and starts no memory cycle. A write to offset 12 starts a memory write of the word {offset 13 byte, written byte}.
- R6: A read of offset 12 starts a memory read and returns bits 7:0 of the word. Bits 15:8 are latched so that a later read of offset 13 returns them without a memory cycle.
- R7: A memory cycle holds its chip select low for WAIT_CYCLES clocks. A read holds output-enable low for all of them. A write drives the data bus for all of them and holds write-enable low for the first WAIT_CYCLES-1. Output-enable and write-enable are never low together.
- R8: A non-triggering access is acknowledged one clock after it is presented. An access to offset 12 is acknowledged WAIT_CYCLES+3 clocks after it is presented. Each acknowledge lasts one clock.
- R9: With control bit 0 set, the 24-bit address grows by 2 after every triggered cycle, wrapping past 0xFFFFFF, with bit 0 kept.
- R10: With host_owns_mem low, every memory output pin equals the matching device-side input, and dev_dq_i always follows mem_dq_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_owns_mem | input | 1 | 1: bridge drives memory pins; 0: device-side pass-through |
| reg_cyc | input | 1 | Register bus cycle valid |
| reg_stb | input | 1 | Register bus strobe |
| reg_we | input | 1 | Register bus write enable |
| reg_adr | input | 4 | Register offset |
| reg_wdat | input | 8 | Register write data |
| reg_rdat | output | 8 | Register read data, valid with reg_ack |
| reg_ack | output | 1 | One-clock acknowledge |
| dev_addr | input | 23 | Device-side word address |
| dev_dq_o | input | 16 | Device-side write data |
| dev_dq_oe | input | 1 | Device-side data drive enable |
| dev_flash_ce_n | input | 1 | Device-side flash select |
| dev_ram_ce_n | input | 1 | Device-side RAM select |
| dev_oe_n | input | 1 | Device-side output enable |
| dev_we_n | input | 1 | Device-side write enable |
| dev_flash_rst_n | input | 1 | Device-side flash reset |
| dev_ram_cre | input | 1 | Device-side RAM configuration enable |
| dev_dq_i | output | 16 | Memory read data to the device side |
| mem_addr | output | 23 | Memory word address |
| mem_dq_o | output | 16 | Memory write data |
| mem_dq_oe | output | 1 | Memory data drive enable |
| mem_dq_i | input | 16 | Memory read data |
| mem_flash_ce_n | output | 1 | Flash chip select, active low |
| mem_ram_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_flash_rst_n | output | 1 | Flash reset, active low |
| mem_ram_cre | output | 1 | RAM configuration enable |

## Verification
The assertions watch, on every clock, that output-enable and write-enable never overlap, that write-enable only falls while the bridge drives the data bus, and that address and selects stay still through a cycle. They also check that a completed cycle is followed by exactly one acknowledge and that auto-increment steps the address by one word. Byte ordering through the staged high byte, the exact acknowledge latency, wrap of the address at the top, the mapping of control bits to pins and the ownership pass-through can only be shown by the bench's scenarios against its memory model.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int WADDR_W    = ADDR_W - 1;
    localparam int OFS_W      = 4;

    localparam logic [OFS_W-1:0] OFS_CTRL = 4'd8;
    localparam logic [OFS_W-1:0] OFS_ADR0 = 4'd9;
    localparam logic [OFS_W-1:0] OFS_DLO  = 4'd12;
    localparam logic [OFS_W-1:0] OFS_DHI  = 4'd13;

    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'hC4;

    localparam int B_FRST = 7;
    localparam int B_FCS  = 6;
    localparam int B_RCS  = 2;
    localparam int B_CRE  = 1;
    localparam int B_AINC = 0;

    typedef struct packed {
        logic [WADDR_W-1:0] addr;
        logic [WORD_W-1:0]  dq;
        logic               dq_oe;
        logic               flash_ce_n;
        logic               ram_ce_n;
        logic               oe_n;
        logic               we_n;
        logic               flash_rst_n;
        logic               ram_cre;
    } mem_pins_t;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

    function automatic logic [ADDR_W-1:0] step_word(input logic [ADDR_W-1:0] a);
        return a + ADDR_W'(2);
    endfunction

endpackage

// File: rtl/xmb_regfile.sv
module xmb_regfile
    import xmb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_cyc,
    input  logic                 bus_stb,
    input  logic                 bus_we,
    input  logic [OFS_W-1:0]     bus_adr,
    input  logic [BYTE_W-1:0]    bus_wdat,
    output logic [BYTE_W-1:0]    bus_rdat,
    output logic                 bus_ack,
    output logic                 start,
    output logic                 start_write,
    output logic [WADDR_W-1:0]   word_addr,
    output logic [WORD_W-1:0]    wr_word,
    output logic [BYTE_W-1:0]    ctrl,
    input  logic [WORD_W-1:0]    rd_word,
    input  logic                 done
);

    logic [BYTE_W-1:0] ctrl_q, dlo_q, dhi_q, rdat_q, rd_mux;
    logic [ADDR_W-1:0] addr_q;
    logic              ack_q, busy_q, start_q, pend_wr_q;
    logic              req;

    assign req = bus_cyc && bus_stb && !ack_q;

    always_comb begin
        rd_mux = '0;
        if (bus_adr == OFS_CTRL) rd_mux = ctrl_q;
        if (bus_adr == OFS_DLO)  rd_mux = dlo_q;
        if (bus_adr == OFS_DHI)  rd_mux = dhi_q;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (bus_adr == OFS_ADR0 + OFS_W'(i))
                rd_mux = addr_q[i*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RESET;
            addr_q    <= '0;
            dlo_q     <= '0;
            dhi_q     <= '0;
            rdat_q    <= '0;
            ack_q     <= 1'b0;
            busy_q    <= 1'b0;
            start_q   <= 1'b0;
            pend_wr_q <= 1'b0;
        end else begin
            ack_q   <= 1'b0;
            start_q <= 1'b0;
            if (busy_q) begin
                if (done) begin
                    busy_q <= 1'b0;
                    ack_q  <= 1'b1;
                    if (pend_wr_q) begin
                        rdat_q <= dlo_q;
                    end else begin
                        dlo_q  <= rd_word[BYTE_W-1:0];
                        dhi_q  <= rd_word[WORD_W-1:BYTE_W];
                        rdat_q <= rd_word[BYTE_W-1:0];
                    end
                    if (ctrl_q[B_AINC])
                        addr_q <= step_word(addr_q);
                end
            end else if (req) begin
                if (bus_adr == OFS_DLO) begin
                    busy_q    <= 1'b1;
                    start_q   <= 1'b1;
                    pend_wr_q <= bus_we;
                    if (bus_we)
                        dlo_q <= bus_wdat;
                end else begin
                    ack_q  <= 1'b1;
                    rdat_q <= rd_mux;
                    if (bus_we) begin
                        if (bus_adr == OFS_CTRL) ctrl_q <= bus_wdat;
                        if (bus_adr == OFS_DHI)  dhi_q  <= bus_wdat;
                        for (int i = 0; i < ADDR_BYTES; i++) begin
                            if (bus_adr == OFS_ADR0 + OFS_W'(i))
                                addr_q[i*BYTE_W +: BYTE_W] <= bus_wdat;
                        end
                    end
                end
            end
        end
    end

    assign bus_rdat    = rdat_q;
    assign bus_ack     = ack_q;
    assign start       = start_q;
    assign start_write = pend_wr_q;
    assign word_addr   = addr_q[ADDR_W-1:1];
    assign wr_word     = {dhi_q, dlo_q};
    assign ctrl        = ctrl_q;

    // R8
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy_q);

    // R8
    done_then_ack_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> bus_ack);

    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);

    // R9
    ainc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (done && busy_q && ctrl_q[B_AINC]) |=> (addr_q == $past(addr_q) + ADDR_W'(2)));

endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
    import xmb_pkg::*;
#(
    parameter int WAIT_CYCLES = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                start_write,
    input  logic [WADDR_W-1:0]  word_addr,
    input  logic [WORD_W-1:0]   wr_word,
    input  logic [BYTE_W-1:0]   ctrl,
    input  logic [WORD_W-1:0]   mem_dq_i,
    output logic [WORD_W-1:0]   rd_word,
    output logic                done,
    output mem_pins_t           pins
);

    localparam int CNT_W = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    seq_state_t         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               is_wr_q, done_q;
    logic [WADDR_W-1:0] addr_q;
    logic [WORD_W-1:0]  data_q, rd_q;
    logic               run;

    assign run = (state_q == SEQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            is_wr_q <= 1'b0;
            done_q  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            rd_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= '0;
                        is_wr_q <= start_write;
                        addr_q  <= word_addr;
                        data_q  <= wr_word;
                    end
                end
                SEQ_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= SEQ_IDLE;
                        done_q  <= 1'b1;
                        if (!is_wr_q)
                            rd_q <= mem_dq_i;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        pins.addr        = addr_q;
        pins.dq          = data_q;
        pins.dq_oe       = run && is_wr_q;
        pins.flash_ce_n  = !(run && !ctrl[B_FCS]);
        pins.ram_ce_n    = !(run && !ctrl[B_RCS]);
        pins.oe_n        = !(run && !is_wr_q);
        pins.we_n        = !(run && is_wr_q && (cnt_q != LAST));
        pins.flash_rst_n = ctrl[B_FRST];
        pins.ram_cre     = ctrl[B_CRE];
    end

    assign rd_word = rd_q;
    assign done    = done_q;

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!pins.oe_n && !pins.we_n));

    // R7
    we_driven_chk: assert property (@(posedge clk) disable iff (rst)
        !pins.we_n |-> pins.dq_oe);

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt_q != '0) |-> ($stable(pins.addr) && $stable(pins.oe_n)));

endmodule

// File: rtl/xmb_mux.sv
module xmb_mux
    import xmb_pkg::*;
(
    input  logic      host_owns,
    input  mem_pins_t bridge_pins,
    input  mem_pins_t dev_pins,
    output mem_pins_t out_pins
);

    assign out_pins = host_owns ? bridge_pins : dev_pins;

endmodule

// File: rtl/xmem_bridge.sv
module xmem_bridge
    import xmb_pkg::*;
#(
    parameter int WAIT_CYCLES = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_owns_mem,
    input  logic                reg_cyc,
    input  logic                reg_stb,
    input  logic                reg_we,
    input  logic [OFS_W-1:0]    reg_adr,
    input  logic [BYTE_W-1:0]   reg_wdat,
    output logic [BYTE_W-1:0]   reg_rdat,
    output logic                reg_ack,
    input  logic [WADDR_W-1:0]  dev_addr,
    input  logic [WORD_W-1:0]   dev_dq_o,
    input  logic                dev_dq_oe,
    input  logic                dev_flash_ce_n,
    input  logic                dev_ram_ce_n,
    input  logic                dev_oe_n,
    input  logic                dev_we_n,
    input  logic                dev_flash_rst_n,
    input  logic                dev_ram_cre,
    output logic [WORD_W-1:0]   dev_dq_i,
    output logic [WADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]   mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [WORD_W-1:0]   mem_dq_i,
    output logic                mem_flash_ce_n,
    output logic                mem_ram_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic                mem_flash_rst_n,
    output logic                mem_ram_cre
);

    logic               start, start_write, done;
    logic [WADDR_W-1:0] word_addr;
    logic [WORD_W-1:0]  wr_word, rd_word;
    logic [BYTE_W-1:0]  ctrl;
    mem_pins_t          bridge_pins, dev_pins, out_pins;

    xmb_regfile u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_cyc     (reg_cyc),
        .bus_stb     (reg_stb),
        .bus_we      (reg_we),
        .bus_adr     (reg_adr),
        .bus_wdat    (reg_wdat),
        .bus_rdat    (reg_rdat),
        .bus_ack     (reg_ack),
        .start       (start),
        .start_write (start_write),
        .word_addr   (word_addr),
        .wr_word     (wr_word),
        .ctrl        (ctrl),
        .rd_word     (rd_word),
        .done        (done)
    );

    xmb_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_write (start_write),
        .word_addr   (word_addr),
        .wr_word     (wr_word),
        .ctrl        (ctrl),
        .mem_dq_i    (mem_dq_i),
        .rd_word     (rd_word),
        .done        (done),
        .pins        (bridge_pins)
    );

    always_comb begin
        dev_pins.addr        = dev_addr;
        dev_pins.dq          = dev_dq_o;
        dev_pins.dq_oe       = dev_dq_oe;
        dev_pins.flash_ce_n  = dev_flash_ce_n;
        dev_pins.ram_ce_n    = dev_ram_ce_n;
        dev_pins.oe_n        = dev_oe_n;
        dev_pins.we_n        = dev_we_n;
        dev_pins.flash_rst_n = dev_flash_rst_n;
        dev_pins.ram_cre     = dev_ram_cre;
    end

    xmb_mux u_mux (
        .host_owns   (host_owns_mem),
        .bridge_pins (bridge_pins),
        .dev_pins    (dev_pins),
        .out_pins    (out_pins)
    );

    assign mem_addr        = out_pins.addr;
    assign mem_dq_o        = out_pins.dq;
    assign mem_dq_oe       = out_pins.dq_oe;
    assign mem_flash_ce_n  = out_pins.flash_ce_n;
    assign mem_ram_ce_n    = out_pins.ram_ce_n;
    assign mem_oe_n        = out_pins.oe_n;
    assign mem_we_n        = out_pins.we_n;
    assign mem_flash_rst_n = out_pins.flash_rst_n;
    assign mem_ram_cre     = out_pins.ram_cre;
    assign dev_dq_i        = mem_dq_i;

endmodule

// File: tb/sim_xmem_bridge.sv
`timescale 1ns/1ps
module sim_xmem_bridge;

    localparam int WAIT = 7;
    localparam int NV   = 33;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_owns_mem = 1'b1;
    logic        reg_cyc = 1'b0, reg_stb = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_adr = '0;
    logic [7:0]  reg_wdat = '0;
    logic [7:0]  reg_rdat;
    logic        reg_ack;
    logic [22:0] dev_addr = '0;
    logic [15:0] dev_dq_o = '0;
    logic        dev_dq_oe = 1'b0, dev_flash_ce_n = 1'b1, dev_ram_ce_n = 1'b1;
    logic        dev_oe_n = 1'b1, dev_we_n = 1'b1, dev_flash_rst_n = 1'b1, dev_ram_cre = 1'b0;
    logic [15:0] dev_dq_i;
    logic [22:0] mem_addr;
    logic [15:0] mem_dq_o, mem_dq_i;
    logic        mem_dq_oe, mem_flash_ce_n, mem_ram_ce_n, mem_oe_n, mem_we_n;
    logic        mem_flash_rst_n, mem_ram_cre;

    logic        force_en = 1'b0;
    logic [15:0] force_val = '0;
    logic [15:0] model [64];

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int st_ce, st_we, st_oe;
    bit st_fce, st_rce;
    logic [22:0] st_addr;

    always #4 clk = ~clk;

    xmem_bridge #(.WAIT_CYCLES(WAIT)) u0 (
        .clk(clk), .rst(rst), .host_owns_mem(host_owns_mem),
        .reg_cyc(reg_cyc), .reg_stb(reg_stb), .reg_we(reg_we), .reg_adr(reg_adr),
        .reg_wdat(reg_wdat), .reg_rdat(reg_rdat), .reg_ack(reg_ack),
        .dev_addr(dev_addr), .dev_dq_o(dev_dq_o), .dev_dq_oe(dev_dq_oe),
        .dev_flash_ce_n(dev_flash_ce_n), .dev_ram_ce_n(dev_ram_ce_n),
        .dev_oe_n(dev_oe_n), .dev_we_n(dev_we_n), .dev_flash_rst_n(dev_flash_rst_n),
        .dev_ram_cre(dev_ram_cre), .dev_dq_i(dev_dq_i),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
        .mem_flash_ce_n(mem_flash_ce_n), .mem_ram_ce_n(mem_ram_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_flash_rst_n(mem_flash_rst_n), .mem_ram_cre(mem_ram_cre)
    );

    // memory model
    always @(posedge clk)
        if (!mem_we_n && (!mem_flash_ce_n || !mem_ram_ce_n))
            model[mem_addr[5:0]] <= mem_dq_o;

    assign mem_dq_i = force_en ? force_val : (!mem_oe_n ? model[mem_addr[5:0]] : 16'h0000);

    // {write, offset, write data, expected read data}
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 4'h8, 8'hC0, 8'h00},
        {1'b1, 4'h9, 8'h10, 8'h00},
        {1'b1, 4'hA, 8'h00, 8'h00},
        {1'b1, 4'hB, 8'h00, 8'h00},
        {1'b1, 4'hD, 8'hAB, 8'h00},
        {1'b1, 4'hC, 8'hCD, 8'h00},
        {1'b0, 4'hC, 8'h00, 8'hCD},
        {1'b0, 4'hD, 8'h00, 8'hAB},
        {1'b0, 4'h8, 8'h00, 8'hC0},
        {1'b0, 4'h9, 8'h00, 8'h10},
        {1'b1, 4'h8, 8'hC1, 8'h00},
        {1'b1, 4'h9, 8'h20, 8'h00},
        {1'b1, 4'hD, 8'h12, 8'h00},
        {1'b1, 4'hC, 8'h34, 8'h00},
        {1'b1, 4'hD, 8'h56, 8'h00},
        {1'b1, 4'hC, 8'h78, 8'h00},
        {1'b0, 4'h9, 8'h00, 8'h24},
        {1'b1, 4'h8, 8'hC0, 8'h00},
        {1'b1, 4'h9, 8'h21, 8'h00},
        {1'b0, 4'hC, 8'h00, 8'h34},
        {1'b0, 4'hD, 8'h00, 8'h12},
        {1'b1, 4'h9, 8'h22, 8'h00},
        {1'b0, 4'hC, 8'h00, 8'h78},
        {1'b0, 4'hD, 8'h00, 8'h56},
        {1'b1, 4'hE, 8'h55, 8'h00},
        {1'b0, 4'hE, 8'h00, 8'h00},
        {1'b1, 4'h3, 8'h77, 8'h00},
        {1'b0, 4'h3, 8'h00, 8'h00},
        {1'b1, 4'hF, 8'h99, 8'h00},
        {1'b0, 4'h8, 8'h00, 8'hC0},
        {1'b0, 4'h9, 8'h00, 8'h22},
        {1'b0, 4'hA, 8'h00, 8'h00},
        {1'b0, 4'hB, 8'h00, 8'h00}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [3:0] adr, input logic [7:0] wd,
                        output logic [7:0] rd, output int lat);
        st_ce = 0; st_we = 0; st_oe = 0; st_fce = 0; st_rce = 0; st_addr = '0;
        @(negedge clk);
        reg_cyc = 1'b1; reg_stb = 1'b1; reg_we = we; reg_adr = adr; reg_wdat = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (!mem_flash_ce_n || !mem_ram_ce_n) begin st_ce++; st_addr = mem_addr; end
            if (!mem_flash_ce_n) st_fce = 1;
            if (!mem_ram_ce_n)   st_rce = 1;
            if (!mem_we_n) st_we++;
            if (!mem_oe_n) st_oe++;
        end while (!reg_ack && lat < 200);
        rd = reg_rdat;
        reg_cyc = 1'b0; reg_stb = 1'b0; reg_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] adr, input logic [7:0] wd);
        logic [7:0] rd; int lat;
        xfer(1'b1, adr, wd, rd, lat);
    endtask

    task automatic rd_chk(input logic [3:0] adr, input logic [7:0] exp, input string tag);
        logic [7:0] rd; int lat;
        xfer(1'b0, adr, 8'h00, rd, lat);
        check(rd == exp, tag, rd, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int lat;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check(mem_flash_ce_n && mem_ram_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
              "R1 idle strobes", {mem_flash_ce_n, mem_ram_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b11110);
        check(mem_flash_rst_n && !mem_ram_cre, "R1 side-band", {mem_flash_rst_n, mem_ram_cre}, 2'b10);
        rd_chk(4'h8, 8'hC4, "R1 ctrl reset");
        rd_chk(4'h9, 8'h00, "R1 addr0 reset");
        rd_chk(4'hA, 8'h00, "R1 addr1 reset");
        rd_chk(4'hB, 8'h00, "R1 addr2 reset");
        rd_chk(4'hD, 8'h00, "R1 data high reset");

        // table walk: R2 R5 R6 R8 R9 R4
        for (int i = 0; i < NV; i++) begin
            logic        v_we;
            logic [3:0]  v_adr;
            logic [7:0]  v_wd, v_exp;
            {v_we, v_adr, v_wd, v_exp} = VEC[i];
            xfer(v_we, v_adr, v_wd, rd, lat);
            if (!v_we) check(rd == v_exp, $sformatf("R2 R6 row %0d data", i), rd, v_exp);
            if (v_adr == 4'hC) begin
                check(lat == WAIT + 3, $sformatf("R8 row %0d trigger latency", i), lat, WAIT + 3);
                check(st_ce == WAIT, $sformatf("R7 row %0d select width", i), st_ce, WAIT);
            end else begin
                check(lat == 1, $sformatf("R8 row %0d plain latency", i), lat, 1);
                check(st_ce == 0, $sformatf("R5 R6 row %0d no memory cycle", i), st_ce, 0);
            end
        end

        // R4 R3 R7 address and write strobes
        wr(4'h8, 8'hC0);
        wr(4'h9, 8'h35); wr(4'hA, 8'h02); wr(4'hB, 8'h80);
        wr(4'hD, 8'hBE);
        xfer(1'b1, 4'hC, 8'hEF, rd, lat);
        check(st_addr == 23'h40011A, "R4 word address", st_addr, 23'h40011A);
        check(st_rce && !st_fce, "R3 RAM only", {st_fce, st_rce}, 2'b01);
        check(st_we == WAIT - 1, "R7 write-enable width", st_we, WAIT - 1);
        check(st_oe == 0, "R7 no output-enable in write", st_oe, 0);
        check(model[6'h1A] == 16'hBEEF, "R5 word written", model[6'h1A], 16'hBEEF);

        // R3 side-band bits and both selects
        wr(4'h8, 8'h02);
        @(negedge clk);
        check(!mem_flash_rst_n && mem_ram_cre, "R3 side-band follow", {mem_flash_rst_n, mem_ram_cre}, 2'b01);
        check(mem_flash_ce_n && mem_ram_ce_n, "R3 selects idle", {mem_flash_ce_n, mem_ram_ce_n}, 2'b11);
        xfer(1'b0, 4'hC, 8'h00, rd, lat);
        check(rd == 8'hEF, "R6 read low", rd, 8'hEF);
        check(st_fce && st_rce, "R3 both selects", {st_fce, st_rce}, 2'b11);
        check(st_oe == WAIT && st_we == 0, "R7 read strobes", st_oe, WAIT);
        rd_chk(4'hD, 8'hBE, "R6 latched high");

        // R9 wrap past top, bit 0 kept
        wr(4'h8, 8'hC1);
        wr(4'h9, 8'hFF); wr(4'hA, 8'hFF); wr(4'hB, 8'hFF);
        wr(4'hD, 8'h00);
        wr(4'hC, 8'h11);
        rd_chk(4'h9, 8'h01, "R9 wrap byte0");
        rd_chk(4'hA, 8'h00, "R9 wrap byte1");
        rd_chk(4'hB, 8'h00, "R9 wrap byte2");

        // R10 ownership pass-through
        host_owns_mem = 1'b0;
        dev_addr = 23'h2A5A5A; dev_dq_o = 16'hC3C3; dev_dq_oe = 1'b1;
        dev_flash_ce_n = 1'b0; dev_ram_ce_n = 1'b1; dev_oe_n = 1'b1; dev_we_n = 1'b1;
        dev_flash_rst_n = 1'b0; dev_ram_cre = 1'b1;
        force_en = 1'b1; force_val = 16'h6D29;
        @(negedge clk);
        check(mem_addr == 23'h2A5A5A && mem_dq_o == 16'hC3C3 && mem_dq_oe,
              "R10 addr/data pass", mem_addr, 23'h2A5A5A);
        check(!mem_flash_ce_n && mem_ram_ce_n && mem_oe_n && mem_we_n &&
              !mem_flash_rst_n && mem_ram_cre, "R10 control pass",
              {mem_flash_ce_n, mem_ram_ce_n, mem_oe_n, mem_we_n, mem_flash_rst_n, mem_ram_cre}, 6'b011101);
        check(dev_dq_i == 16'h6D29, "R10 read data pass", dev_dq_i, 16'h6D29);
        wr(4'h8, 8'hC0);
        xfer(1'b1, 4'hC, 8'h22, rd, lat);
        check(st_we == 0 && st_rce == 0, "R10 bridge hidden", st_we, 0);
        force_en = 1'b0;
        host_owns_mem = 1'b1;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule